// File: doc/BRIEF.md
# Key-locked system control register file

A bank of 32-bit words for chip-level control: reset and clock-gating controls, clock selection, pin multiplexing, scratch space, strap and identification words. Software reaches it over a simple request bus: one request per cycle with valid, write, byte address and write data. Every request is answered on the following cycle with read data, a read-valid flag and an error pulse.

Writes into the low window of the map are gated by a one-bit key flag. Software sets the flag by writing a parameterized magic value to word 0. Any other value written there clears it. The strap word has two write addresses, one that sets bits and one that clears them. The second of these is the revision word, which never changes after it loads. A group of read-only words ignores writes. A random-data word returns a value from a free-running LFSR on every read. Addresses past the end of the map, and addresses that are not word aligned, are refused.

The strap value, the revision value and the initial key flag come from input ports. They are captured on the first clock edge after reset is released. The rest of the map comes up with fixed defaults.

Top module: `sysctl_regfile`

## Requirements
- R1: A write to byte 0x00 sets the key flag to 1 when the data equals the MAGIC parameter and to 0 for any other data. A read of 0x00 returns the flag in bit 0 with bits 31:1 zero.
- R2: While the key flag is 0, a write to any word index from 1 to PROT_END-1 (default 64, byte 0x100) leaves every word unchanged and pulses err_o. Words at index PROT_END and above stay writable while the key flag is 0.
- R3: With the key flag at 1, a write to the strap word at byte 0x70 ORs the data into its current value.
- R4: With the key flag at 1, a write to byte 0x7C clears the strap bits that are 1 in the data. The revision word read at 0x7C keeps the value of rev_i.
- R5: Writes to the read-only words are ignored with no error pulse. These are 0x14 (frequency result), 0x50 to 0x6C (eight scratch words), 0xE0 and 0xE4 (counters, both 0x000000FF), and 0x150 and 0x154 (chip ID, parameters CHIP_ID_LO and CHIP_ID_HI).
- R6: Each read of byte 0x78 returns the current LFSR value. That value is never zero, and two reads in different cycles return different values, whatever the control word at 0x74 holds. Writes to 0x78 are ignored.
- R7: An access whose word index (address bits ADDR_W-1:2) is NUM_WORDS or more is ignored on write, returns 0 on read, and pulses err_o.
- R8: An access with address bits 1:0 not zero is handled like R7: the write is ignored, a read returns 0, and err_o pulses.
- R9: rdata_o, rvalid_o and err_o respond one cycle after the request. rvalid_o is 1 only for reads. err_o is 1 only in the cycle after a refused request.
- R10: After reset, the defaults are 0x04=0xFFFFFFF0, 0x08=0x00030000, 0x0C=0x1F003E00, 0x2C=0x00000010, 0x74=0x0000000E and 0x84=0x0000F000. Every other writable word is 0. Strap, revision and key flag take strap_i, rev_i and key_init_i on the first clock edge after release, and a request made on that edge is dropped.
- R11: Every other in-range word stores the full 32-bit write data, subject to R2, and returns it on read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 32 | Strap value captured after reset |
| rev_i | input | 32 | Silicon revision captured after reset |
| key_init_i | input | 1 | Initial key flag captured after reset |
| req_valid_i | input | 1 | Request valid |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| rvalid_o | output | 1 | Read response valid |
| err_o | output | 1 | Request refused (out of range, misaligned or locked) |

## Verification
The bound checker watches the following on every cycle:
- the key word reads back as a single bit;
- a locked write to the first control word leaves it untouched and raises the error;
- a strap set-write produces the OR of the old value and the data;
- out-of-range reads return zero;
- response and error pulses only ever follow a matching request.

Other behaviours depend on the history of requests, so only the bench scenarios can show them:
- a clear through the revision address;
- the read-only words after many writes;
- fresh random data across reads;
- reloading of the ports after a second reset.

The bench checks these against its own model of the map, under random traffic that mixes lock changes, misaligned and out-of-range addresses.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  // word indices whose position the decoder depends on
  localparam int unsigned W_KEY     = 0;
  localparam int unsigned W_FREQ    = 5;
  localparam int unsigned W_SCR_LO  = 20;
  localparam int unsigned W_SCR_HI  = 27;
  localparam int unsigned W_STRAP   = 28;
  localparam int unsigned W_RNG_CTL = 29;
  localparam int unsigned W_RNG     = 30;
  localparam int unsigned W_REV     = 31;
  localparam int unsigned W_FRC_LO  = 56;
  localparam int unsigned W_FRC_HI  = 57;
  localparam int unsigned W_ID_LO   = 84;
  localparam int unsigned W_ID_HI   = 85;

  typedef enum logic [2:0] {
    K_KEY,
    K_PLAIN,
    K_RO,
    K_RNG,
    K_STRAP_SET,
    K_STRAP_CLR
  } word_kind_e;

  function automatic word_kind_e kind_of(int unsigned w);
    if (w == W_KEY)   return K_KEY;
    if (w == W_RNG)   return K_RNG;
    if (w == W_STRAP) return K_STRAP_SET;
    if (w == W_REV)   return K_STRAP_CLR;
    if (w == W_FREQ || (w >= W_SCR_LO && w <= W_SCR_HI) ||
        w == W_FRC_LO || w == W_FRC_HI || w == W_ID_LO || w == W_ID_HI)
      return K_RO;
    return K_PLAIN;
  endfunction

  function automatic logic [31:0] reset_value(int unsigned w);
    case (w)
      1:         return 32'hFFFF_FFF0;
      2:         return 32'h0003_0000;
      3:         return 32'h1F00_3E00;
      11:        return 32'h0000_0010;
      W_RNG_CTL: return 32'h0000_000E;
      33:        return 32'h0000_F000;
      W_FRC_LO:  return 32'h0000_00FF;
      W_FRC_HI:  return 32'h0000_00FF;
      default:   return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_addr_dec.sv
module sysctl_addr_dec
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_WORDS = 128,
  parameter int unsigned PROT_END  = 64,
  parameter int unsigned IDX_W     = 7
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              unlocked_i,
  input  logic              boot_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              wr_ok_o,
  output logic              rd_ok_o,
  output logic              rd_req_o,
  output logic              bad_o,
  output logic              blocked_o
);

  logic [ADDR_W-3:0] word_f;
  logic              req, in_range, aligned, bad_any, prot, locked_hit;
  word_kind_e        kind;

  assign word_f   = addr_i[ADDR_W-1:2];
  assign idx_o    = word_f[IDX_W-1:0];
  assign in_range = 32'(word_f) < NUM_WORDS;
  assign aligned  = addr_i[1:0] == 2'b00;
  assign req      = valid_i & ~boot_i;
  assign bad_any  = ~aligned | ~in_range;
  assign kind     = kind_of(32'(idx_o));

  assign prot       = (idx_o != '0) && (32'(idx_o) < PROT_END);
  assign locked_hit = prot & ~unlocked_i;

  assign bad_o     = req & bad_any;
  assign blocked_o = req & write_i & ~bad_any & locked_hit;
  assign wr_ok_o   = req & write_i & ~bad_any & ~locked_hit &
                     (kind != K_RO) & (kind != K_RNG);
  assign rd_ok_o   = req & ~write_i & ~bad_any;
  assign rd_req_o  = req & ~write_i;

endmodule

// File: rtl/sysctl_key_lock.sv
module sysctl_key_lock #(
  parameter logic [31:0] MAGIC = 32'hC0DE_5EED
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        boot_i,
  input  logic        init_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic        unlocked_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     unlocked_o <= 1'b0;
    else if (boot_i) unlocked_o <= init_i;
    else if (wr_i)   unlocked_o <= (wdata_i == MAGIC);
  end

endmodule

// File: rtl/sysctl_rng_lfsr.sv
module sysctl_rng_lfsr #(
  parameter int unsigned      WIDTH = 32,
  parameter logic [WIDTH-1:0] SEED  = 32'h1ACE_B00C,
  parameter logic [WIDTH-1:0] TAPS  = 32'h8020_0003
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [WIDTH-1:0] value_o
);

  // Galois form, advances every cycle; nonzero seed keeps it out of the zero state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) value_o <= SEED;
    else         value_o <= (value_o >> 1) ^ (value_o[0] ? TAPS : '0);
  end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned NUM_WORDS  = 128,
  parameter int unsigned PROT_END   = 64,
  parameter logic [31:0] MAGIC      = 32'hC0DE_5EED,
  parameter logic [31:0] CHIP_ID_LO = 32'h5EC0_0001,
  parameter logic [31:0] CHIP_ID_HI = 32'h0000_2A17,
  parameter logic [31:0] RNG_SEED   = 32'h1ACE_B00C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       strap_i,
  input  logic [31:0]       rev_i,
  input  logic              key_init_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  output logic              err_o
);

  localparam int unsigned IDX_W = $clog2(NUM_WORDS);

  logic             boot_q;
  logic             key_flag;
  logic [31:0]      rng_value;
  logic [IDX_W-1:0] idx;
  logic             wr_ok, rd_ok, rd_req, bad, blocked;
  logic [31:0]      word_q [NUM_WORDS];

  // one load cycle after reset release for port-sourced words
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) boot_q <= 1'b1;
    else         boot_q <= 1'b0;
  end

  sysctl_addr_dec #(
    .ADDR_W    (ADDR_W),
    .NUM_WORDS (NUM_WORDS),
    .PROT_END  (PROT_END),
    .IDX_W     (IDX_W)
  ) u_dec (
    .valid_i    (req_valid_i),
    .write_i    (req_write_i),
    .addr_i     (req_addr_i),
    .unlocked_i (key_flag),
    .boot_i     (boot_q),
    .idx_o      (idx),
    .wr_ok_o    (wr_ok),
    .rd_ok_o    (rd_ok),
    .rd_req_o   (rd_req),
    .bad_o      (bad),
    .blocked_o  (blocked)
  );

  sysctl_key_lock #(.MAGIC(MAGIC)) u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boot_i     (boot_q),
    .init_i     (key_init_i),
    .wr_i       (wr_ok && idx == IDX_W'(W_KEY)),
    .wdata_i    (req_wdata_i),
    .unlocked_o (key_flag)
  );

  sysctl_rng_lfsr #(.WIDTH(32), .SEED(RNG_SEED)) u_rng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .value_o (rng_value)
  );

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    if (i == W_KEY) begin : g_key
      assign word_q[i] = {31'b0, key_flag};
    end else if (i == W_RNG) begin : g_rng
      assign word_q[i] = rng_value;
    end else if (i == W_STRAP) begin : g_strap
      logic [31:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              q <= '0;
        else if (boot_q)                          q <= strap_i;
        else if (wr_ok && idx == IDX_W'(W_STRAP)) q <= q | req_wdata_i;
        else if (wr_ok && idx == IDX_W'(W_REV))   q <= q & ~req_wdata_i;
      end
      assign word_q[i] = q;
    end else if (i == W_REV) begin : g_rev
      logic [31:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q <= '0;
        else if (boot_q) q <= rev_i;
      end
      assign word_q[i] = q;
    end else if (kind_of(i) == K_RO) begin : g_ro
      assign word_q[i] = (i == W_ID_LO) ? CHIP_ID_LO :
                         (i == W_ID_HI) ? CHIP_ID_HI : reset_value(i);
    end else begin : g_plain
      logic [31:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                      q <= reset_value(i);
        else if (wr_ok && idx == IDX_W'(i)) q <= req_wdata_i;
      end
      assign word_q[i] = q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      rdata_o  <= rd_ok ? word_q[idx] : '0;
      rvalid_o <= rd_req;
      err_o    <= bad | blocked;
    end
  end

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_WORDS = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [31:0]       req_wdata_i,
  input logic [31:0]       rdata_o,
  input logic              rvalid_o,
  input logic              err_o,
  input logic              key_flag,
  input logic              boot,
  input logic [31:0]       strap_q,
  input logic [31:0]       ctl_q
);

  // R1
  key_read_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_addr_i == '0 && !boot)
      |=> (rvalid_o && rdata_o[31:1] == '0));

  // R2
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_addr_i == ADDR_W'(32'h4) && !key_flag && !boot)
      |=> ($stable(ctl_q) && err_o));

  // R3
  strap_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_addr_i == ADDR_W'(32'h70) && key_flag && !boot)
      |=> (strap_q == ($past(strap_q) | $past(req_wdata_i))));

  // R7
  range_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && 32'(req_addr_i[ADDR_W-1:2]) >= NUM_WORDS && !boot)
      |=> (rdata_o == '0 && err_o));

  // R9
  err_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_valid_i));

  // R9
  rvalid_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_valid_i && !req_write_i));

endmodule

bind sysctl_regfile sysctl_regfile_chk #(
  .ADDR_W    (ADDR_W),
  .NUM_WORDS (NUM_WORDS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_wdata_i (req_wdata_i),
  .rdata_o     (rdata_o),
  .rvalid_o    (rvalid_o),
  .err_o       (err_o),
  .key_flag    (key_flag),
  .boot        (boot_q),
  .strap_q     (word_q[sysctl_pkg::W_STRAP]),
  .ctl_q       (word_q[1])
);

// File: tb/sim_sysctl_regfile.sv
module sim_sysctl_regfile;

  localparam logic [31:0] MAGIC = 32'hC0DE_5EED;
  localparam logic [31:0] STRAP = 32'h0000_0A50;
  localparam logic [31:0] REV   = 32'h0503_0303;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] strap_i = STRAP;
  logic [31:0] rev_i = REV;
  logic        key_init_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [11:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o, err_o;

  always #4 clk = ~clk;

  sysctl_regfile u0 (
    .clk_i(clk), .rst_ni(rst_ni), .strap_i(strap_i), .rev_i(rev_i),
    .key_init_i(key_init_i), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .err_o(err_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] mem [128];
  bit key_m;
  logic [31:0] got_rd;
  logic got_rv, got_er;
  logic [31:0] rng_prev;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_ro(int w);
    return w == 5 || (w >= 20 && w <= 27) || w == 56 || w == 57 || w == 84 || w == 85;
  endfunction

  function automatic bit is_bad(logic [11:0] a);
    return a[1:0] != 2'b00 || a[11:2] >= 10'd128;
  endfunction

  function automatic string tag_of(bit wr, logic [11:0] a);
    int w = int'(a[11:2]);
    if (a[1:0] != 0) return "R8";
    if (w >= 128) return "R7";
    if (w == 0) return "R1";
    if (wr && w < 64 && !key_m) return "R2";
    if (w == 28) return "R3";
    if (w == 31) return "R4";
    if (w == 30) return "R6";
    if (is_ro(w)) return "R5";
    return "R11";
  endfunction

  task automatic model_reset(input bit key_init);
    foreach (mem[i]) mem[i] = '0;
    mem[1] = 32'hFFFF_FFF0; mem[2] = 32'h0003_0000; mem[3] = 32'h1F00_3E00;
    mem[11] = 32'h0000_0010; mem[29] = 32'h0000_000E; mem[33] = 32'h0000_F000;
    mem[56] = 32'h0000_00FF; mem[57] = 32'h0000_00FF;
    mem[84] = 32'h5EC0_0001; mem[85] = 32'h0000_2A17;
    mem[28] = STRAP; mem[31] = REV;
    key_m = key_init;
  endtask

  task automatic do_reset(input bit key_init);
    @(negedge clk);
    rst_ni = 1'b0; key_init_i = key_init; req_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    model_reset(key_init);
  endtask

  task automatic acc(input bit wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = a; req_wdata_i = d;
    @(negedge clk);
    got_rd = rdata_o; got_rv = rvalid_o; got_er = err_o;
    req_valid_i = 1'b0;
  endtask

  // access with the model predicting data, rvalid and err
  task automatic run(input bit wr, input logic [11:0] a, input logic [31:0] d);
    string t = tag_of(wr, a);
    int w = int'(a[11:2]);
    bit e_er = 0;
    logic [31:0] e_rd = '0;
    if (is_bad(a)) e_er = 1;
    else if (wr) begin
      if (w == 0) key_m = (d == MAGIC);
      else if (w < 64 && !key_m) e_er = 1;
      else if (w == 28) mem[28] = mem[28] | d;
      else if (w == 31) mem[28] = mem[28] & ~d;
      else if (!is_ro(w) && w != 30) mem[w] = d;
    end else e_rd = (w == 0) ? {31'b0, key_m} : mem[w];
    acc(wr, a, d);
    chk({t, " err"}, {31'b0, got_er}, {31'b0, e_er});
    chk({"R9 rvalid ", t}, {31'b0, got_rv}, {31'b0, !wr});
    if (!wr && !(w == 30 && !is_bad(a))) chk({t, " rdata"}, got_rd, e_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset(1'b0);

    // R10 reset state
    for (int w = 0; w < 128; w++) if (w != 30) run(0, 12'(w * 4), '0);

    // R1 key handling
    run(1, 12'h000, MAGIC + 1);
    run(0, 12'h000, '0);
    run(1, 12'h000, MAGIC);
    run(0, 12'h000, '0);
    run(1, 12'h000, ~MAGIC);
    // R2 locked writes refused, upper words still writable
    run(1, 12'h004, 32'h1234_5678);
    run(0, 12'h004, '0);
    run(1, 12'h0FC, 32'hDEAD_0001);
    run(0, 12'h0FC, '0);
    run(1, 12'h100, 32'hCAFE_0100);
    run(0, 12'h100, '0);
    run(1, 12'h070, 32'hFFFF_0000);
    run(0, 12'h070, '0);
    // R3 / R4 strap set and clear
    run(1, 12'h000, MAGIC);
    run(1, 12'h070, 32'h8000_0001);
    run(0, 12'h070, '0);
    run(1, 12'h07C, 32'h0000_0A41);
    run(0, 12'h070, '0);
    run(0, 12'h07C, '0);
    // R5 read-only words
    run(1, 12'h014, 32'hFFFF_FFFF);
    run(0, 12'h014, '0);
    run(1, 12'h05C, 32'h1111_1111);
    run(0, 12'h05C, '0);
    run(1, 12'h0E4, 32'h0);
    run(0, 12'h0E4, '0);
    run(1, 12'h150, 32'h0);
    run(0, 12'h150, '0);
    run(1, 12'h154, 32'hFFFF_FFFF);
    run(0, 12'h154, '0);
    // R6 random word fresh regardless of its control word
    run(1, 12'h074, 32'h0);
    acc(0, 12'h078, '0); rng_prev = got_rd;
    chk("R6 rng nonzero", {31'b0, got_rd == 0}, 32'h0);
    acc(0, 12'h078, '0);
    chk("R6 rng fresh", {31'b0, got_rd == rng_prev}, 32'h0);
    run(1, 12'h074, 32'h0000_000E);
    rng_prev = got_rd;
    acc(0, 12'h078, '0);
    chk("R6 rng fresh enabled", {31'b0, got_rd == rng_prev}, 32'h0);
    run(1, 12'h078, 32'h0);
    acc(0, 12'h078, '0);
    chk("R6 rng write ignored", {31'b0, got_rd == 0}, 32'h0);
    // R7 / R8 refused addresses
    run(1, 12'h200, 32'h5555_5555);
    run(0, 12'h200, '0);
    run(0, 12'hFFC, '0);
    run(1, 12'h106, 32'h7777_7777);
    run(0, 12'h104, '0);
    run(0, 12'h101, '0);
    // R11 plain word
    run(1, 12'h008, 32'hA5A5_5A5A);
    run(0, 12'h008, '0);

    // random traffic
    for (int n = 0; n < 1500; n++) begin
      int sel = $urandom_range(0, 99);
      logic [11:0] a;
      logic [31:0] d = $urandom();
      bit wr = $urandom_range(0, 1) == 1;
      if (sel < 8) begin
        a = 12'h000; wr = 1;
        if ($urandom_range(0, 1) == 1) d = MAGIC;
      end else if (sel < 16) a = {10'($urandom_range(128, 1023)), 2'b00};
      else if (sel < 24) a = {10'($urandom_range(0, 127)), 2'($urandom_range(1, 3))};
      else if (sel < 40) begin
        int pick = $urandom_range(0, 4);
        a = (pick == 0) ? 12'h070 : (pick == 1) ? 12'h07C : (pick == 2) ? 12'h078 :
            (pick == 3) ? 12'h150 : 12'h060;
      end else a = {10'($urandom_range(0, 127)), 2'b00};
      run(wr, a, d);
    end

    // R10 second reset with key flag from port, modified words back to defaults
    do_reset(1'b1);
    run(0, 12'h000, '0);
    run(0, 12'h008, '0);
    run(0, 12'h070, '0);
    run(1, 12'h004, 32'h0BAD_F00D);
    run(0, 12'h004, '0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule